// File: doc/BRIEF.md
# Byte-Programmed PWM Generator with Auto-Off Timer

This block drives one pulse-width-modulated output. A host sets it up through a write-only port that carries an 8-bit address and 8-bit data on a one-cycle strobe. The period and the high time are both 16-bit counts of a time-base tick, which is 125 ns at the intended 8 MHz rate. A tick-enable input tells the block when a tick occurs. Each 16-bit setting is sent as two bytes. Writing the high byte only holds it in a staging register. Writing the low byte loads the whole value at once, so the host never loads a half-updated number. The output is high at the start of each period and low for the rest of it.

An enable register turns the output on and off. A separate 16-bit auto-off timer counts down in large units of time-base ticks while the output is on. When the timer runs out, it clears the enable on its own. Loading the timer with all ones turns this shut-down off. A period change waits for the current period to end. A new high time applies at once.

Top module: `pwm_byte_ctl`

## Requirements
- R1: Address map: 0xA1 and 0xA2 are the auto-off high and low bytes, 0xA3 is enable, 0xA4 and 0xA5 are the period low and high bytes, and 0xA6 and 0xA7 are the high-time low and high bytes. A high-byte write only stages its byte and does not change the output. A low-byte write loads {staged high byte, written byte}.
- R2: While enabled, the period counter advances by one on each cycle with tick_en high. A period P>0 lasts P ticks. The output is high during the first D ticks of every period, where D is the high time.
- R3: If the high time is greater than or equal to the period, the output stays high for the whole period.
- R4: A high time of 0 holds the output low. A later non-zero high time gives its normal waveform without any enable write.
- R5: While the active period is 0, the output is held low.
- R6: A newly written period takes effect only at the next period boundary. A newly written high time takes effect at once.
- R7: Writing the enable register with bit 0 = 1 turns the output on. Bit 0 = 0 turns it off in the cycle after the write. Turning the output on starts a new period from count 0.
- R8: While enabled, the auto-off value counts down once per 2^UNIT_W ticks (65536 by default). The tick prescaler restarts when the low byte of the auto-off value is written. When the count runs out, enable is cleared. A loaded value of 0 or 1 ends after one unit.
- R9: An auto-off value of 0xFFFF never counts down, and the output stays enabled indefinitely.
- R10: Reset clears the output, the enable, the period and the high time, and sets the auto-off value to 0xFFFF.
- R11: While tick_en is low, the period counter and the auto-off prescaler hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Time-base tick qualifier |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM signal |

## Verification
The bench changes the period in the middle of a period and counts high cycles in a window that ends before the old period would end. A design that applied the period at once would report no pulse in that window. It writes only a high byte and checks that the waveform is unchanged, which catches a design that loads the value on the high-byte write. It drives the high time to 0 and back without an enable write, and sets the high time above the period, to expose comparators that stick or wrap. It runs the auto-off timer to expiry with a reduced unit and then with the all-ones code. A design that counted down the disable code, or ignored expiry, would leave the output wrongly on or wrongly off.

// File: rtl/pwm_byte_pkg.sv
package pwm_byte_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned VAL_W  = 2 * BYTE_W;

   localparam logic [7:0] DEF_ADR_TMR_HI  = 8'hA1;
   localparam logic [7:0] DEF_ADR_TMR_LO  = 8'hA2;
   localparam logic [7:0] DEF_ADR_EN      = 8'hA3;
   localparam logic [7:0] DEF_ADR_PER_LO  = 8'hA4;
   localparam logic [7:0] DEF_ADR_PER_HI  = 8'hA5;
   localparam logic [7:0] DEF_ADR_DUTY_LO = 8'hA6;
   localparam logic [7:0] DEF_ADR_DUTY_HI = 8'hA7;

   typedef logic [VAL_W-1:0] cnt_t;
endpackage

// File: rtl/pwm_byte_stage.sv
module pwm_byte_stage #(
   parameter int unsigned  ADDR_W = 8,
   parameter int unsigned  BYTE_W = 8,
   parameter logic [ADDR_W-1:0] ADR_HI = '0,
   parameter logic [ADDR_W-1:0] ADR_LO = '0,
   localparam int unsigned VAL_W  = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [VAL_W-1:0]  val_q
);
   logic [BYTE_W-1:0] hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q  <= '0;
         val_q <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADR_HI) hi_q  <= wr_data;
         if (wr_addr == ADR_LO) val_q <= {hi_q, wr_data};
      end
   end
endmodule

// File: rtl/pwm_byte_gen.sv
module pwm_byte_gen #(
   parameter int unsigned VAL_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             en,
   input  logic [VAL_W-1:0] pend_per,
   input  logic [VAL_W-1:0] duty,
   output logic [VAL_W-1:0] cnt_q,
   output logic [VAL_W-1:0] act_per_q,
   output logic             pwm
);
   logic [VAL_W-1:0] last_w;
   logic             wrap_w;

   assign last_w = act_per_q - VAL_W'(1);
   assign wrap_w = (act_per_q == '0) || (cnt_q == last_w);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         act_per_q <= '0;
      end else if (!en) begin
         cnt_q     <= '0;
         act_per_q <= pend_per;
      end else if (tick_en) begin
         if (wrap_w) begin
            cnt_q     <= '0;
            act_per_q <= pend_per;
         end else begin
            cnt_q <= cnt_q + VAL_W'(1);
         end
      end
   end

   assign pwm = en && (act_per_q != '0) && (cnt_q < duty);
endmodule

// File: rtl/pwm_byte_autooff.sv
module pwm_byte_autooff #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned UNIT_W = 16,
   parameter bit          PRESENT = 1'b1,
   parameter logic [ADDR_W-1:0] ADR_HI = '0,
   parameter logic [ADDR_W-1:0] ADR_LO = '0,
   localparam int unsigned VAL_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [VAL_W-1:0]  rem_q,
   output logic              expire
);
   localparam logic [VAL_W-1:0] OFF_CODE = '1;

   generate
      if (PRESENT) begin : g_timer
         logic [BYTE_W-1:0] hi_q;
         logic [UNIT_W-1:0] pre_q;
         logic              load_w;
         logic              unit_w;

         assign load_w = wr_en && (wr_addr == ADR_LO);
         assign unit_w = en && tick_en && (&pre_q);
         assign expire = unit_w && !load_w && (rem_q != OFF_CODE)
                         && (rem_q <= VAL_W'(1));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hi_q  <= '0;
               pre_q <= '0;
               rem_q <= OFF_CODE;
            end else begin
               if (wr_en && (wr_addr == ADR_HI)) hi_q <= wr_data;
               if (load_w) begin
                  pre_q <= '0;
                  rem_q <= {hi_q, wr_data};
               end else if (en && tick_en) begin
                  pre_q <= pre_q + UNIT_W'(1);
                  if (unit_w && (rem_q != OFF_CODE)) begin
                     rem_q <= (rem_q <= VAL_W'(1)) ? '0 : rem_q - VAL_W'(1);
                  end
               end
            end
         end
      end else begin : g_no_timer
         assign rem_q  = OFF_CODE;
         assign expire = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pwm_byte_ctl.sv
module pwm_byte_ctl
   import pwm_byte_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned UNIT_W      = 16,
   parameter bit          AUTO_OFF_EN = 1'b1,
   parameter logic [ADDR_W-1:0] ADR_TMR_HI  = DEF_ADR_TMR_HI,
   parameter logic [ADDR_W-1:0] ADR_TMR_LO  = DEF_ADR_TMR_LO,
   parameter logic [ADDR_W-1:0] ADR_EN      = DEF_ADR_EN,
   parameter logic [ADDR_W-1:0] ADR_PER_LO  = DEF_ADR_PER_LO,
   parameter logic [ADDR_W-1:0] ADR_PER_HI  = DEF_ADR_PER_HI,
   parameter logic [ADDR_W-1:0] ADR_DUTY_LO = DEF_ADR_DUTY_LO,
   parameter logic [ADDR_W-1:0] ADR_DUTY_HI = DEF_ADR_DUTY_HI
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              pwm_out
);
   localparam int unsigned NSET = 2;
   localparam logic [NSET*ADDR_W-1:0] HI_ADRS = {ADR_DUTY_HI, ADR_PER_HI};
   localparam logic [NSET*ADDR_W-1:0] LO_ADRS = {ADR_DUTY_LO, ADR_PER_LO};

   logic [NSET-1:0][VAL_W-1:0] set_q;
   cnt_t pend_per, duty_q, cnt_q, act_per_q, tmr_rem;
   logic en_q, expire, pwm_w;

   genvar gi;
   generate
      for (gi = 0; gi < NSET; gi++) begin : g_set
         pwm_byte_stage #(
            .ADDR_W (ADDR_W),
            .BYTE_W (BYTE_W),
            .ADR_HI (HI_ADRS[gi*ADDR_W +: ADDR_W]),
            .ADR_LO (LO_ADRS[gi*ADDR_W +: ADDR_W])
         ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .val_q   (set_q[gi])
         );
      end
   endgenerate

   assign pend_per = set_q[0];
   assign duty_q   = set_q[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (wr_en && (wr_addr == ADR_EN)) begin
         en_q <= wr_data[0];
      end else if (expire) begin
         en_q <= 1'b0;
      end
   end

   pwm_byte_autooff #(
      .ADDR_W  (ADDR_W),
      .BYTE_W  (BYTE_W),
      .UNIT_W  (UNIT_W),
      .PRESENT (AUTO_OFF_EN),
      .ADR_HI  (ADR_TMR_HI),
      .ADR_LO  (ADR_TMR_LO)
   ) u_auto (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .en      (en_q),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rem_q   (tmr_rem),
      .expire  (expire)
   );

   pwm_byte_gen #(.VAL_W(VAL_W)) u_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .en        (en_q),
      .pend_per  (pend_per),
      .duty      (duty_q),
      .cnt_q     (cnt_q),
      .act_per_q (act_per_q),
      .pwm       (pwm_w)
   );

   assign pwm_out = pwm_w;
endmodule

// File: rtl/pwm_byte_chk.sv
module pwm_byte_chk #(
   parameter int unsigned VAL_W  = 16,
   parameter int unsigned ADDR_W = 8,
   parameter logic [ADDR_W-1:0] ADR_TMR_LO = '0,
   parameter logic [ADDR_W-1:0] ADR_EN     = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              en_q,
   input logic [VAL_W-1:0]  cnt_q,
   input logic [VAL_W-1:0]  act_per_q,
   input logic [VAL_W-1:0]  duty_q,
   input logic [VAL_W-1:0]  tmr_rem,
   input logic              pwm_out
);
   AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !pwm_out); // R7
   AST_PER_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (act_per_q == '0) |-> !pwm_out); // R5
   AST_DUTY_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_q == '0) |-> !pwm_out); // R4
   AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && (act_per_q != '0) && (duty_q >= act_per_q)) |-> pwm_out); // R3
   AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (act_per_q != '0) |-> (cnt_q < act_per_q)); // R2
   AST_PER_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_per_q) |-> (cnt_q == '0)); // R6
   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !tick_en && !(wr_en && (wr_addr == ADR_EN))) |=> $stable(cnt_q)); // R11
   AST_OFF_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ((tmr_rem == '1) && !(wr_en && (wr_addr == ADR_TMR_LO))) |=> (tmr_rem == '1)); // R9
endmodule

bind pwm_byte_ctl pwm_byte_chk #(
   .VAL_W      (pwm_byte_pkg::VAL_W),
   .ADDR_W     (ADDR_W),
   .ADR_TMR_LO (ADR_TMR_LO),
   .ADR_EN     (ADR_EN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .en_q      (en_q),
   .cnt_q     (cnt_q),
   .act_per_q (act_per_q),
   .duty_q    (duty_q),
   .tmr_rem   (tmr_rem),
   .pwm_out   (pwm_out)
);

// File: tb/pwm_byte_ctl_bench.sv
module pwm_byte_ctl_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_TMR_HI = 8'hA1, A_TMR_LO = 8'hA2, A_EN = 8'hA3,
                          A_PER_LO = 8'hA4, A_PER_HI = 8'hA5,
                          A_DUTY_LO = 8'hA6, A_DUTY_HI = 8'hA7;
   localparam int NVEC = 8;
   // {period, duty, expected high ticks per period}
   localparam logic [47:0] VEC [NVEC] = '{
      {16'd10,  16'd3,   16'd3},
      {16'd10,  16'd0,   16'd0},
      {16'd10,  16'd10,  16'd10},
      {16'd10,  16'd15,  16'd10},
      {16'd0,   16'd5,   16'd0},
      {16'd1,   16'd1,   16'd1},
      {16'd256, 16'd128, 16'd128},
      {16'd5,   16'd1,   16'd1}
   };

   logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b1, wr_en = 1'b0;
   logic [7:0] wr_addr = '0, wr_data = '0;
   logic pwm_out;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_byte_ctl #(.UNIT_W(8)) u_pwm_byte_ctl (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic measure(input int n, input bit half, output int highs);
      highs = 0;
      for (int i = 0; i < n; i++) begin
         tick_en = half ? (i % 2 == 0) : 1'b1;
         @(posedge clk); @(negedge clk);
         if (pwm_out) highs++;
      end
      tick_en = 1'b1;
   endtask

   task automatic setup(input logic [15:0] per, input logic [15:0] dty);
      wr(A_EN, 8'h00);
      wr(A_PER_HI, per[15:8]); wr(A_DUTY_HI, dty[15:8]);
      wr(A_PER_LO, per[7:0]);  wr(A_DUTY_LO, dty[7:0]);
      wr(A_EN, 8'h01);
   endtask

   initial begin
      int h;
      repeat (3) @(negedge clk);
      chk("R10 output low in reset", pwm_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      wr(A_EN, 8'h01);
      measure(20, 1'b0, h);
      chk("R10/R5 period zero after reset", h, 0);

      for (int v = 0; v < NVEC; v++) begin
         int win;
         setup(VEC[v][47:32], VEC[v][31:16]);
         win = (VEC[v][47:32] == 16'd0) ? 8 : 2 * int'(VEC[v][47:32]);
         measure(win, 1'b0, h);
         chk($sformatf("R2/R3/R4/R5 vector %0d", v), h, 2 * int'(VEC[v][15:0]));
      end

      // R1: high byte alone changes nothing, low byte loads
      setup(16'd10, 16'd3);
      wr(A_DUTY_HI, 8'h01);
      measure(20, 1'b0, h);
      chk("R1 high byte only stages", h, 6);
      wr(A_DUTY_LO, 8'h00);
      measure(20, 1'b0, h);
      chk("R1/R3 low byte loads 0x100", h, 20);

      // R4: zero high time then recovery without enable toggle
      wr(A_DUTY_HI, 8'h00); wr(A_DUTY_LO, 8'h00);
      measure(20, 1'b0, h);
      chk("R4 zero high time low", h, 0);
      wr(A_DUTY_LO, 8'h04);
      measure(20, 1'b0, h);
      chk("R4 recovery after zero", h, 8);

      // R7: disable
      wr(A_EN, 8'h00);
      chk("R7 off right after write", pwm_out, 0);
      measure(20, 1'b0, h);
      chk("R7 stays off", h, 0);

      // R6: period change waits for boundary
      setup(16'd10, 16'd2);
      wr(A_PER_HI, 8'h00); wr(A_PER_LO, 8'd20);
      measure(17, 1'b0, h);
      chk("R6 period at boundary", h, 2);

      // R11: half-rate ticks stretch the waveform
      setup(16'd4, 16'd2);
      measure(16, 1'b1, h);
      chk("R11 tick qualifier", h, 8);

      // R8: auto-off with 2 units of 256 ticks
      wr(A_EN, 8'h00);
      wr(A_TMR_HI, 8'h00); wr(A_TMR_LO, 8'h02);
      setup(16'd4, 16'd2);
      measure(400, 1'b0, h);
      chk("R8 running before expiry", h, 200);
      measure(150, 1'b0, h);
      measure(20, 1'b0, h);
      chk("R8 off after expiry", h, 0);

      // R9: all-ones disables auto-off
      wr(A_TMR_HI, 8'hFF); wr(A_TMR_LO, 8'hFF);
      wr(A_EN, 8'h01);
      measure(700, 1'b0, h);
      chk("R9 off code never expires", h, 350);

      // R10: reset in mid-run
      rst_n = 1'b0;
      @(posedge clk); @(negedge clk);
      chk("R10 reset clears output", pwm_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      wr(A_EN, 8'h01);
      measure(20, 1'b0, h);
      chk("R10 period cleared by reset", h, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule